// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block sits behind the bit-level receiver of an I2C target and decides, byte by byte, whether the address phase of a transfer names this device. The receiver hands it each completed byte with a one-cycle strobe, plus one-cycle pulses for a start, a repeated start and a stop condition. The block compares the address bits against a configured 10-bit own address. A per-bit don't-care mask relaxes the compare, and a bypass input forces an exact compare.

It answers with a registered acknowledge decision one clock after each strobe. With that decision come two pulses. One reports a match on the own address and the other reports an accepted general call, so the controller can tell the two apart. Reserved address codes are refused no matter what the mask allows. In 10-bit mode the header byte is acknowledged first, and the full match is declared only after the second byte. A later read header that follows a repeated start is accepted only if the full address already matched in the same transfer.

Top module: `i2c_addr_filter`

## Requirements
- R1: After a synchronous active-high reset, `ack_o`, `hit_o` and `gcall_o` are 0. They are single-cycle pulses that change only in the clock that follows a cycle with `byte_vld`=1, and they are 0 in every other cycle.
- R2: In 7-bit mode (`ten_bit_mode`=0) the first byte after a start or repeated start is decoded with bits 7:1 as the address and bit 0 as R/W. The byte gives `ack_o`=1 and `hit_o`=1 when bits 7:1 equal `own_addr[6:0]` at every position where `addr_mask[6:0]` holds 0. A mask bit of 1 makes that position don't-care.
- R3: A first byte whose address is reserved never gives any output, whatever the mask. The reserved set is address 0000000 with R/W=1, addresses 0000001, 0000010 and 0000011, 00001xx, and 11111xx with either R/W. In 7-bit mode, 11110xx is also refused.
- R4: A first byte of 0x00 (address 0000000, R/W=0) is a general call. In either mode it gives `ack_o`=1 and `gcall_o`=1 with `hit_o`=0 when `gc_en`=1, and gives no output when `gc_en`=0.
- R5: While `mask_bypass`=1 the mask is ignored, and every compare needs every address bit to be equal.
- R6: In 10-bit mode (`ten_bit_mode`=1) a first byte of the form 11110, A9, A8, 0 gives `ack_o`=1 with `hit_o`=0 when A9:A8 match `own_addr[9:8]` under `addr_mask[9:8]`. The next byte then gives `ack_o`=1 and `hit_o`=1 when it matches `own_addr[7:0]` under `addr_mask[7:0]`. Any other first byte that is not a general call gives no output in this mode.
- R7: In 10-bit mode a first byte of the form 11110, A9, A8, 1 gives `ack_o`=1 and `hit_o`=1 only under two conditions: A9:A8 match, and the full 10-bit address matched after the most recent start, with only repeated starts in between. After a start or a stop the earlier match is forgotten.
- R8: Bytes that arrive before any start, after a stop, or after the address phase of a transfer has been decided give no output, even when they look like an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_start | input | 1 | One-cycle pulse: start condition seen |
| cond_restart | input | 1 | One-cycle pulse: repeated start seen |
| cond_stop | input | 1 | One-cycle pulse: stop condition seen |
| byte_vld | input | 1 | Strobe: `byte_data` holds a complete received byte |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| addr_mask | input | 10 | Per-bit don't-care mask, 1 = ignore that bit |
| mask_bypass | input | 1 | 1 = ignore mask and compare exactly |
| gc_en | input | 1 | 1 = accept the general call |
| ten_bit_mode | input | 1 | 0 = 7-bit addressing, 1 = 10-bit addressing |
| ack_o | output | 1 | Acknowledge decision for the strobed byte |
| hit_o | output | 1 | Own-address match pulse |
| gcall_o | output | 1 | General-call accepted pulse |

## Verification
The assertions assume several things about the inputs. The configuration inputs (`ten_bit_mode`, `own_addr`, `addr_mask`, `mask_bypass`, `gc_en`) stay steady during a transfer, so a 7-bit acknowledge always belongs to a first byte. A byte strobe never shares a cycle with a start, repeated start or stop pulse. The stimulus honours both: it changes configuration only before a start, and it drives conditions and bytes on separate clocks. Random sweeps draw own addresses built to agree or disagree with the received bits under the drawn mask. Directed cases then push every reserved code with an all-ones mask and run 10-bit write, repeated-start read and stop sequences.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_LOW  = 2'd2,
    PH_DATA = 2'd3
  } phase_t;

  typedef struct packed {
    logic ack;
    logic hit;
    logic gcall;
  } verdict_t;

  localparam logic [4:0] TEN_HDR = 5'b11110;

endpackage

// File: rtl/masked_eq.sv
module masked_eq #(
  parameter int W = 7
) (
  input  logic [W-1:0] rx,
  input  logic [W-1:0] ref_bits,
  input  logic [W-1:0] dont_care,
  output logic         eq
);
  logic [W-1:0] bit_ok;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      assign bit_ok[i] = dont_care[i] | (rx[i] ~^ ref_bits[i]);
    end
  endgenerate

  assign eq = &bit_ok;
endmodule

// File: rtl/byte_classify.sv
module byte_classify
  import i2cam_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rw,
  output logic              is_gcall,
  output logic              is_reserved,
  output logic              is_ten_hdr
);
  localparam int AW = BYTE_W - 1;

  logic [AW-1:0] a;
  logic          low_block;
  logic          top_block;

  assign a  = rx_byte[BYTE_W-1:1];
  assign rw = rx_byte[0];

  // 0000000..0000111: start byte (R/W=1), CBUS, two spares, high-speed codes
  always_comb begin
    low_block = 1'b0;
    if (a[AW-1:2] == '0) begin
      if (a[1:0] != 2'b00) low_block = 1'b1;
      else                 low_block = rw;
    end
    if ((a[AW-1:3] == '0) && a[2]) low_block = 1'b1;
  end

  assign top_block   = (a[AW-1:2] == 5'b11111);
  assign is_reserved = low_block | top_block;
  assign is_gcall    = (rx_byte == '0);
  assign is_ten_hdr  = (a[AW-1:2] == TEN_HDR);
endmodule

// File: rtl/addr_decide.sv
module addr_decide
  import i2cam_pkg::*;
(
  input  phase_t   phase,
  input  logic     hit10,
  input  logic     cond_start,
  input  logic     cond_restart,
  input  logic     cond_stop,
  input  logic     byte_vld,
  input  logic     ten_bit_mode,
  input  logic     gc_en,
  input  logic     rw,
  input  logic     is_gcall,
  input  logic     is_reserved,
  input  logic     is_ten_hdr,
  input  logic     eq_short,
  input  logic     eq_hi,
  input  logic     eq_lo,
  output verdict_t verdict,
  output phase_t   phase_nxt,
  output logic     hit10_nxt
);
  always_comb begin
    verdict   = '0;
    phase_nxt = phase;
    hit10_nxt = hit10;
    if (cond_stop) begin
      phase_nxt = PH_IDLE;
      hit10_nxt = 1'b0;
    end else if (cond_start) begin
      phase_nxt = PH_ADDR;
      hit10_nxt = 1'b0;
    end else if (cond_restart) begin
      phase_nxt = PH_ADDR;
    end else if (byte_vld) begin
      unique case (phase)
        PH_ADDR: begin
          phase_nxt = PH_DATA;
          if (is_gcall) begin
            verdict.ack   = gc_en;
            verdict.gcall = gc_en;
          end else if (!ten_bit_mode) begin
            if (!is_reserved && !is_ten_hdr && eq_short) begin
              verdict.ack = 1'b1;
              verdict.hit = 1'b1;
            end
          end else if (is_ten_hdr && eq_hi) begin
            if (!rw) begin
              verdict.ack = 1'b1;
              phase_nxt   = PH_LOW;
              hit10_nxt   = 1'b0;
            end else if (hit10) begin
              verdict.ack = 1'b1;
              verdict.hit = 1'b1;
            end
          end
        end
        PH_LOW: begin
          phase_nxt = PH_DATA;
          hit10_nxt = eq_lo;
          if (eq_lo) begin
            verdict.ack = 1'b1;
            verdict.hit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_addr_filter.sv
module i2c_addr_filter
  import i2cam_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cond_start,
  input  logic              cond_restart,
  input  logic              cond_stop,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] addr_mask,
  input  logic              mask_bypass,
  input  logic              gc_en,
  input  logic              ten_bit_mode,
  output logic              ack_o,
  output logic              hit_o,
  output logic              gcall_o
);
  localparam int SHORT_W = BYTE_W - 1;
  localparam int HI_W    = ADDR_W - BYTE_W;

  phase_t      phase_q, phase_d;
  logic        hit10_q, hit10_d;
  verdict_t    verdict_d, verdict_q;
  logic [ADDR_W-1:0] dc_bits;
  logic        rw, is_gcall, is_reserved, is_ten_hdr;
  logic        eq_short, eq_hi, eq_lo;

  assign dc_bits = mask_bypass ? '0 : addr_mask;

  byte_classify #(.BYTE_W(BYTE_W)) u_class (
    .rx_byte    (byte_data),
    .rw         (rw),
    .is_gcall   (is_gcall),
    .is_reserved(is_reserved),
    .is_ten_hdr (is_ten_hdr)
  );

  masked_eq #(.W(SHORT_W)) u_eq_short (
    .rx       (byte_data[BYTE_W-1:1]),
    .ref_bits (own_addr[SHORT_W-1:0]),
    .dont_care(dc_bits[SHORT_W-1:0]),
    .eq       (eq_short)
  );

  masked_eq #(.W(HI_W)) u_eq_hi (
    .rx       (byte_data[HI_W:1]),
    .ref_bits (own_addr[ADDR_W-1:BYTE_W]),
    .dont_care(dc_bits[ADDR_W-1:BYTE_W]),
    .eq       (eq_hi)
  );

  masked_eq #(.W(BYTE_W)) u_eq_lo (
    .rx       (byte_data),
    .ref_bits (own_addr[BYTE_W-1:0]),
    .dont_care(dc_bits[BYTE_W-1:0]),
    .eq       (eq_lo)
  );

  addr_decide u_decide (
    .phase       (phase_q),
    .hit10       (hit10_q),
    .cond_start  (cond_start),
    .cond_restart(cond_restart),
    .cond_stop   (cond_stop),
    .byte_vld    (byte_vld),
    .ten_bit_mode(ten_bit_mode),
    .gc_en       (gc_en),
    .rw          (rw),
    .is_gcall    (is_gcall),
    .is_reserved (is_reserved),
    .is_ten_hdr  (is_ten_hdr),
    .eq_short    (eq_short),
    .eq_hi       (eq_hi),
    .eq_lo       (eq_lo),
    .verdict     (verdict_d),
    .phase_nxt   (phase_d),
    .hit10_nxt   (hit10_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      hit10_q   <= 1'b0;
      verdict_q <= '0;
    end else begin
      phase_q   <= phase_d;
      hit10_q   <= hit10_d;
      verdict_q <= verdict_d;
    end
  end

  assign ack_o   = verdict_q.ack;
  assign hit_o   = verdict_q.hit;
  assign gcall_o = verdict_q.gcall;
endmodule

// File: rtl/i2c_addr_filter_chk.sv
module i2c_addr_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic [7:0] byte_data,
  input logic [6:0] own7,
  input logic [6:0] mask7,
  input logic       mask_bypass,
  input logic       gc_en,
  input logic       ten_bit_mode,
  input logic       ack_o,
  input logic       hit_o,
  input logic       gcall_o
);
  function automatic logic banned7(input logic [7:0] b);
    logic [6:0] a;
    a = b[7:1];
    return (a >= 7'd1 && a <= 7'd7) || (a == 7'd0 && b[0]) || (a >= 7'h78);
  endfunction

  assert_quiet_without_strobe_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(byte_vld) |-> !(ack_o || hit_o || gcall_o));

  assert_hit_is_acked_R2: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (ack_o && !gcall_o));

  assert_masked_compare_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !$past(ten_bit_mode)) |->
      ((($past(byte_data[7:1]) ^ $past(own7)) & ~$past(mask7)) == 7'd0));

  assert_no_reserved_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (ack_o && !gcall_o && !$past(ten_bit_mode)) |-> !banned7($past(byte_data)));

  assert_gcall_needs_enable_R4: assert property (@(posedge clk) disable iff (rst)
    gcall_o |-> ($past(gc_en) && ($past(byte_data) == 8'h00) && ack_o));

  assert_exact_when_bypassed_R5: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !$past(ten_bit_mode) && $past(mask_bypass)) |->
      ($past(byte_data[7:1]) == $past(own7)));
endmodule

bind i2c_addr_filter i2c_addr_filter_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .byte_vld    (byte_vld),
  .byte_data   (byte_data),
  .own7        (own_addr[6:0]),
  .mask7       (addr_mask[6:0]),
  .mask_bypass (mask_bypass),
  .gc_en       (gc_en),
  .ten_bit_mode(ten_bit_mode),
  .ack_o       (ack_o),
  .hit_o       (hit_o),
  .gcall_o     (gcall_o)
);

// File: tb/i2c_addr_filter_test.sv
module i2c_addr_filter_test;
  localparam int CLK_NS = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cond_start = 0, cond_restart = 0, cond_stop = 0;
  logic       byte_vld = 0;
  logic [7:0] byte_data = 0;
  logic [9:0] own_addr = 0, addr_mask = 0;
  logic       mask_bypass = 0, gc_en = 0, ten_bit_mode = 0;
  logic       ack_o, hit_o, gcall_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  i2c_addr_filter uut (
    .clk(clk), .rst(rst),
    .cond_start(cond_start), .cond_restart(cond_restart), .cond_stop(cond_stop),
    .byte_vld(byte_vld), .byte_data(byte_data),
    .own_addr(own_addr), .addr_mask(addr_mask),
    .mask_bypass(mask_bypass), .gc_en(gc_en), .ten_bit_mode(ten_bit_mode),
    .ack_o(ack_o), .hit_o(hit_o), .gcall_o(gcall_o)
  );

  // expected outputs packed as {ack, hit, gcall}
  function automatic logic is_rsv(input logic [7:0] b);
    logic [6:0] a;
    a = b[7:1];
    if (a[6:3] == 4'b0000) return !(a == 7'd0 && !b[0]);
    return (a[6:2] == 5'b11111) || (a[6:2] == 5'b11110);
  endfunction

  function automatic logic [2:0] ref7(input logic [7:0] b, input logic [6:0] own,
                                      input logic [6:0] msk, input logic byp, input logic gce);
    logic [6:0] m;
    if (b == 8'h00) return {gce, 1'b0, gce};
    if (is_rsv(b)) return 3'b000;
    m = byp ? 7'd0 : msk;
    return (((b[7:1] ^ own) & ~m) == 7'd0) ? 3'b110 : 3'b000;
  endfunction

  function automatic logic meq(input logic [7:0] x, input logic [7:0] y, input logic [7:0] m);
    return ((x ^ y) & ~m) == 8'd0;
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual={ack,hit,gcall}=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic pulse_cond(input int kind);
    @(negedge clk);
    cond_start   = (kind == 0);
    cond_restart = (kind == 1);
    cond_stop    = (kind == 2);
    @(negedge clk);
    cond_start = 0; cond_restart = 0; cond_stop = 0;
  endtask

  task automatic send(input logic [7:0] b, output logic [2:0] r);
    @(negedge clk);
    byte_vld  = 1;
    byte_data = b;
    @(negedge clk);
    byte_vld = 0;
    r = {ack_o, hit_o, gcall_o};
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [2:0] r;
    logic [7:0] eff;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    check("R1 reset", {ack_o, hit_o, gcall_o}, 3'b000);
    rst = 0;
    @(negedge clk);
    check("R1 after reset", {ack_o, hit_o, gcall_o}, 3'b000);

    // R8: bytes before any start are ignored
    gc_en = 1; own_addr = 10'h055; addr_mask = 0;
    send(8'h00, r);  check("R8 pre-start gcall", r, 3'b000);
    send(8'hAA, r);  check("R8 pre-start own", r, 3'b000);

    // R2 R3 R4 R5: sweep every first byte in 7-bit mode
    ten_bit_mode = 0;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      string tag;
      b = i[7:0];
      addr_mask   = ($urandom % 4 == 0) ? 10'd0 : 10'($urandom);
      mask_bypass = ($urandom % 4 == 0);
      gc_en       = $urandom % 2;
      own_addr    = ($urandom % 2) ? {3'($urandom), b[7:1] ^ (7'($urandom) & addr_mask[6:0])}
                                   : 10'($urandom);
      if (b == 8'h00)   tag = "R4 gcall";
      else if (is_rsv(b)) tag = "R3 reserved";
      else if (mask_bypass) tag = "R5 bypass";
      else tag = "R2 masked";
      pulse_cond(0);
      send(b, r);
      check(tag, r, ref7(b, own_addr[6:0], addr_mask[6:0], mask_bypass, gc_en));
      pulse_cond(2);
    end

    // R3: every reserved code with an all-ones mask and a matching own address
    addr_mask = 10'h3FF; mask_bypass = 0; gc_en = 1;
    for (int i = 1; i < 256; i++) begin
      if (is_rsv(i[7:0])) begin
        own_addr = {3'b0, i[7:1]};
        pulse_cond(0);
        send(i[7:0], r);
        check("R3 reserved all-mask", r, 3'b000);
        pulse_cond(2);
      end
    end

    // R1: outputs fall back to zero the cycle after a hit
    addr_mask = 0; own_addr = 10'h02A;
    pulse_cond(0);
    send({7'h2A, 1'b0}, r);  check("R2 directed hit", r, 3'b110);
    @(negedge clk);
    check("R1 single pulse", {ack_o, hit_o, gcall_o}, 3'b000);
    send(8'h54, r);  check("R8 data byte after match", r, 3'b000);
    pulse_cond(2);

    // R4 general call with enable off / on in 10-bit mode
    ten_bit_mode = 1;
    gc_en = 0; pulse_cond(0); send(8'h00, r); check("R4 gcall disabled", r, 3'b000); pulse_cond(2);
    gc_en = 1; pulse_cond(0); send(8'h00, r); check("R4 gcall 10-bit", r, 3'b101); pulse_cond(2);

    // R6: 7-bit style first byte is not accepted in 10-bit mode
    own_addr = 10'h02A; addr_mask = 0;
    pulse_cond(0); send(8'h54, r); check("R6 plain byte in 10-bit", r, 3'b000); pulse_cond(2);

    // R6 R7 R8: random 10-bit transactions
    for (int k = 0; k < 60; k++) begin
      logic [1:0] hb;
      logic [7:0] lo;
      logic hi_ok, lo_ok;
      addr_mask   = ($urandom % 3 == 0) ? 10'd0 : 10'($urandom);
      mask_bypass = ($urandom % 4 == 0);
      own_addr    = 10'($urandom);
      eff = mask_bypass ? 8'd0 : addr_mask[7:0];
      hb  = ($urandom % 4 != 0) ? own_addr[9:8] ^ (2'($urandom) & addr_mask[9:8]) : 2'($urandom);
      lo  = ($urandom % 4 != 0) ? own_addr[7:0] ^ (8'($urandom) & addr_mask[7:0]) : 8'($urandom);
      hi_ok = meq({6'd0, hb}, {6'd0, own_addr[9:8]},
                  {6'd0, mask_bypass ? 2'b00 : addr_mask[9:8]});
      lo_ok = meq(lo, own_addr[7:0], eff);
      pulse_cond(0);
      send({5'b11110, hb, 1'b0}, r);
      check("R6 header write", r, {hi_ok, 2'b00});
      send(lo, r);
      check(hi_ok ? "R6 second byte" : "R8 byte after refused header", r,
            {hi_ok && lo_ok, hi_ok && lo_ok, 1'b0});
      pulse_cond(1);
      send({5'b11110, hb, 1'b1}, r);
      check("R7 restart read", r, {hi_ok && lo_ok, hi_ok && lo_ok, 1'b0});
      send(8'h00, r);
      check("R8 data phase", r, 3'b000);
      if (hi_ok && lo_ok) begin
        pulse_cond(2);
        pulse_cond(0);
        send({5'b11110, hb, 1'b1}, r);
        check("R7 read after fresh start", r, 3'b000);
      end
      pulse_cond(2);
      send({5'b11110, hb, 1'b0}, r);
      check("R8 after stop", r, 3'b000);
    end

    summary();
    $finish;
  end
endmodule